// File: doc/BRIEF.md
# Serial ADC Readout Host Controller

This block is the host-side master for a delta-sigma converter read over a four-wire serial link. The host drives the converter's clock from outside and reads one full result per chip-select cycle. On a start request the controller pulls chip select low while the serial clock stays low. It then polls the converter's data line until that line reads 0, which means the conversion has finished. Next it issues exactly 32 clock pulses. On each rising edge a configuration bit is presented on the host data output and a result bit is captured from the converter data input.

The configuration word selects the channel and the conversion options for the following conversion. Its layout is fixed: a leading `1`, a `0`, an enable flag, the single-ended flag, the odd flag, three address bits, then an optional second group made of enable-2, input mode, two filter bits and a speed bit. All remaining bits are sent as zero. The 32 received bits are split into an end-of-conversion flag, a zero flag, a sign bit and a 29-bit magnitude field. These are presented together with a one-cycle valid strobe.

A hold option keeps chip select low after the transfer, so the host can watch the data line for the next end of conversion. That falling edge is reported as a one-cycle event. A timeout aborts the wait when the converter never reports completion. The serial clock half-period is a parameter in system clocks.

Top module: `adc_rd_host`

States: `ST_IDLE` (chip select high), `ST_SELECT` (chip select low, polling the data line), `ST_CLK_LO` and `ST_CLK_HI` (the two serial clock phases), `ST_DONE` (frame complete), `ST_ABORT` (timeout) and `ST_MONITOR` (chip select held low between transfers).

Transitions:
- `ST_IDLE`→`ST_SELECT` on start.
- `ST_SELECT`→`ST_CLK_LO` when the data line reads 0.
- `ST_SELECT`→`ST_ABORT` when the wait expires.
- `ST_CLK_LO`→`ST_CLK_HI` on a phase tick.
- `ST_CLK_HI`→`ST_CLK_LO` on a phase tick before the last bit.
- `ST_CLK_HI`→`ST_DONE` on the tick of the last bit.
- `ST_DONE`→`ST_MONITOR` if hold is set, otherwise `ST_DONE`→`ST_IDLE`.
- `ST_ABORT`→`ST_IDLE`.
- `ST_MONITOR`→`ST_SELECT` on start, or `ST_MONITOR`→`ST_IDLE` when hold drops.

## Requirements
- R1: `sclk` is low out of reset and on every falling edge of `cs_n`, and `sclk` is never high while `cs_n` is high.
- R2: After a start, no rising edge of `sclk` occurs until `miso` has been sampled 0 while `cs_n` is low.
- R3: Each completed transfer produces exactly FRAME (32) rising edges of `sclk`. Each high phase lasts DIV clocks, and consecutive rising edges are 2*DIV clocks apart.
- R4: `mosi` changes only while `sclk` is low. The first 13 bits sent, first bit first, are 1, 0, `cfg_en`, `cfg_sgl`, `cfg_odd`, `cfg_addr[2]`, `cfg_addr[1]`, `cfg_addr[0]`, `cfg_en2`, `cfg_im`, `cfg_filt[1]`, `cfg_filt[0]`, `cfg_spd`. The remaining 19 bits are 0.
- R5: The first received bit appears on `rd_eoc`, the second on `rd_zero` and the third on `rd_sign`. The last 29 bits appear on `rd_data`, MSB first. `rd_valid` pulses high for exactly one cycle, one clock after the last falling edge of `sclk`.
- R6: With `hold_cs` high at the end of a transfer, `cs_n` stays low. A 1-to-0 change of `miso` then pulses `conv_irq`, and a start from this state runs a transfer without a new `cs_n` falling edge. With `hold_cs` low, `cs_n` goes high one clock after the last `sclk` falling edge.
- R7: `err_proto` is updated with `rd_valid` and is high exactly when the second received bit was 1.
- R8: If `miso` stays 1 for TMO_CYC clocks after select, the controller raises `cs_n`, pulses `err_tmo` for one cycle, issues no `sclk` edge and gives no `rd_valid`.
- R9: A start request while `busy` is high is ignored. `busy` is low in idle and in monitoring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, accepted when not busy |
| hold_cs | input | 1 | Keep chip select low after the transfer |
| cfg_en | input | 1 | Enable bit of the channel byte |
| cfg_sgl | input | 1 | Single-ended select |
| cfg_odd | input | 1 | Odd/sign select |
| cfg_addr | input | 3 | Channel address |
| cfg_en2 | input | 1 | Enable bit of the option byte |
| cfg_im | input | 1 | Input-mode bit |
| cfg_filt | input | 2 | Filter select bits |
| cfg_spd | input | 1 | Speed bit |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_eoc | output | 1 | First received bit |
| rd_zero | output | 1 | Second received bit |
| rd_sign | output | 1 | Sign bit |
| rd_data | output | 29 | Result magnitude, MSB first |
| err_proto | output | 1 | Second received bit was not 0 |
| err_tmo | output | 1 | One-cycle end-of-conversion timeout pulse |
| conv_irq | output | 1 | One-cycle end-of-conversion event while monitoring |

## Verification
- **Result and chip select:** `rd_valid` and the result fields follow the last `sclk` falling edge by one clock. `cs_n` rises in that same clock when hold is off. The bench records the cycle of every `sclk` edge and compares the lag at the strobe against exactly one.
- **Serial clock timing:** rising edges must be 2*DIV clocks apart and each high phase must last DIV clocks. The device model measures both on every edge.
- **Sampling:** all ports are sampled at the falling system-clock edge, half a cycle after they settle.
- **Timeout and interrupt:** `err_tmo` arrives TMO_CYC clocks into the wait, and `conv_irq` arrives one clock after `miso` falls. The bench polls for both inside bounded windows.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_DONE,
        ST_ABORT,
        ST_MONITOR
    } host_state_t;

    localparam int CFG_BITS = 13;

    // Leading marker pair, channel byte, then option group; first bit is MSB.
    function automatic logic [CFG_BITS-1:0] pack_cfg(
        input logic       en,
        input logic       sgl,
        input logic       odd,
        input logic [2:0] addr,
        input logic       en2,
        input logic       im,
        input logic [1:0] filt,
        input logic       spd
    );
        return {1'b1, 1'b0, en, sgl, odd, addr, en2, im, filt, spd};
    endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_wait.sv
module adc_rd_wait #(
    parameter int TMO_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

    logic [TW-1:0] cnt;

    assign expired = arm && (cnt == TW'(TMO_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int FRAME = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FRAME-1:0] load_word,
    input  logic             adv,
    input  logic             capture,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [FRAME-1:0] rx_word
);
    logic [FRAME-1:0] tx_q;

    assign ser_out = tx_q[FRAME-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (adv) begin
            tx_q <= {tx_q[FRAME-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (capture) begin
            rx_word <= {rx_word[FRAME-2:0], ser_in};
        end
    end
endmodule

// File: rtl/adc_rd_host.sv
module adc_rd_host
    import adc_rd_pkg::*;
#(
    parameter int DIV     = 2,
    parameter int TMO_CYC = 4096,
    parameter int FRAME   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hold_cs,
    input  logic             cfg_en,
    input  logic             cfg_sgl,
    input  logic             cfg_odd,
    input  logic [2:0]       cfg_addr,
    input  logic             cfg_en2,
    input  logic             cfg_im,
    input  logic [1:0]       cfg_filt,
    input  logic             cfg_spd,
    input  logic             miso,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             rd_valid,
    output logic             rd_eoc,
    output logic             rd_zero,
    output logic             rd_sign,
    output logic [FRAME-4:0] rd_data,
    output logic             err_proto,
    output logic             err_tmo,
    output logic             conv_irq
);
    localparam int BW  = $clog2(FRAME);
    localparam int PAD = FRAME - CFG_BITS;

    host_state_t state, state_nx;

    logic             tick;
    logic             expired;
    logic             load;
    logic             rise_now;
    logic             fall_now;
    logic             last_bit;
    logic [BW-1:0]    bit_cnt;
    logic [FRAME-1:0] tx_word;
    logic [FRAME-1:0] rx_word;
    logic             miso_q;

    assign tx_word  = {pack_cfg(cfg_en, cfg_sgl, cfg_odd, cfg_addr,
                                cfg_en2, cfg_im, cfg_filt, cfg_spd), {PAD{1'b0}}};
    assign load     = start && (state == ST_IDLE || state == ST_MONITOR);
    assign rise_now = (state == ST_CLK_LO) && tick;
    assign fall_now = (state == ST_CLK_HI) && tick;
    assign last_bit = (bit_cnt == BW'(FRAME - 1));

    adc_rd_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_CLK_LO || state == ST_CLK_HI),
        .tick  (tick)
    );

    adc_rd_wait #(.TMO_CYC(TMO_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state == ST_SELECT && miso),
        .expired (expired)
    );

    adc_rd_shift #(.FRAME(FRAME)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (tx_word),
        .adv       (fall_now),
        .capture   (rise_now),
        .ser_in    (miso),
        .ser_out   (mosi),
        .rx_word   (rx_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_SELECT;
            end
            ST_SELECT: begin
                if (!miso)        state_nx = ST_CLK_LO;
                else if (expired) state_nx = ST_ABORT;
            end
            ST_CLK_LO: begin
                if (tick) state_nx = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                if (tick) state_nx = last_bit ? ST_DONE : ST_CLK_LO;
            end
            ST_DONE: begin
                state_nx = hold_cs ? ST_MONITOR : ST_IDLE;
            end
            ST_ABORT: begin
                state_nx = ST_IDLE;
            end
            ST_MONITOR: begin
                if (start)         state_nx = ST_SELECT;
                else if (!hold_cs) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Pin outputs decoded from the state
    always_comb begin
        cs_n = (state == ST_IDLE) || (state == ST_ABORT);
        sclk = (state == ST_CLK_HI);
        busy = (state != ST_IDLE) && (state != ST_MONITOR);
    end

    // Bit counter: cleared at frame load, advanced at each falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (load) begin
            bit_cnt <= '0;
        end else if (fall_now) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Result and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_eoc    <= 1'b0;
            rd_zero   <= 1'b0;
            rd_sign   <= 1'b0;
            rd_data   <= '0;
            err_proto <= 1'b0;
            err_tmo   <= 1'b0;
            conv_irq  <= 1'b0;
            miso_q    <= 1'b1;
        end else begin
            rd_valid <= (state == ST_DONE);
            err_tmo  <= (state == ST_ABORT);
            conv_irq <= (state == ST_MONITOR) && miso_q && !miso;
            miso_q   <= miso;
            if (state == ST_DONE) begin
                rd_eoc    <= rx_word[FRAME-1];
                rd_zero   <= rx_word[FRAME-2];
                rd_sign   <= rx_word[FRAME-3];
                rd_data   <= rx_word[FRAME-4:0];
                err_proto <= rx_word[FRAME-2];
            end
        end
    end
endmodule

// File: rtl/adc_rd_host_chk.sv
module adc_rd_host_chk #(
    parameter int FRAME = 32
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic miso,
    input logic rd_valid,
    input logic err_tmo
);
    localparam int CW = $clog2(FRAME) + 2;

    logic          sclk_q;
    logic          eoc_seen;
    logic [CW-1:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            eoc_seen <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n || rd_valid) eoc_seen <= 1'b0;
            else if (!miso)       eoc_seen <= 1'b1;
            if (rd_valid || err_tmo)  rise_cnt <= '0;
            else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    AST_SCK_LOW_AT_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk); // R1
    AST_SCK_ONLY_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R1
    AST_FIRST_RISE_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> eoc_seen); // R2
    AST_PULSES_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rise_cnt == CW'(FRAME))); // R3
    AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi)); // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R5
    AST_TMO_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> cs_n); // R8
    AST_VALID_EXCLUDES_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && err_tmo)); // R8
endmodule

bind adc_rd_host adc_rd_host_chk #(.FRAME(FRAME)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .miso     (miso),
    .rd_valid (rd_valid),
    .err_tmo  (err_tmo)
);

// File: tb/adc_rd_host_test.sv
`timescale 1ns/1ps
module adc_rd_host_test;
    localparam int DIV   = 2;
    localparam int TMO   = 64;
    localparam int FRAME = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 0, hold_cs = 0;
    logic        cfg_en = 0, cfg_sgl = 0, cfg_odd = 0, cfg_en2 = 0, cfg_im = 0, cfg_spd = 0;
    logic [2:0]  cfg_addr = '0;
    logic [1:0]  cfg_filt = '0;
    logic        miso;
    logic        cs_n, sclk, mosi, busy, rd_valid, rd_eoc, rd_zero, rd_sign;
    logic [28:0] rd_data;
    logic        err_proto, err_tmo, conv_irq;

    adc_rd_host #(.DIV(DIV), .TMO_CYC(TMO), .FRAME(FRAME)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .hold_cs(hold_cs),
        .cfg_en(cfg_en), .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd), .cfg_addr(cfg_addr),
        .cfg_en2(cfg_en2), .cfg_im(cfg_im), .cfg_filt(cfg_filt), .cfg_spd(cfg_spd),
        .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy),
        .rd_valid(rd_valid), .rd_eoc(rd_eoc), .rd_zero(rd_zero), .rd_sign(rd_sign),
        .rd_data(rd_data), .err_proto(err_proto), .err_tmo(err_tmo), .conv_irq(conv_irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    // Behavioural converter model
    int          conv_left = 0;
    int          conv_len  = 20;
    logic        in_io     = 0;
    int          fall_cnt  = 0;
    logic [31:0] dev_word  = '0;
    logic [31:0] cfg_rx    = '0;
    int          rises = 0, last_rise = -1000, last_fall = -1000;
    int          per_bad = 0, early = 0, cs_bad = 0, cs_falls = 0;

    assign miso = cs_n ? 1'b1 : (in_io ? dev_word[31 - fall_cnt] : (conv_left != 0));

    always @(negedge clk) if (conv_left > 0) conv_left--;

    always @(posedge sclk) begin
        if (cs_n) cs_bad++;
        if (!in_io) begin
            in_io = 1'b1;
            fall_cnt = 0;
            if (conv_left != 0) early++;
        end else if (cyc - last_rise != 2 * DIV) begin
            per_bad++;
        end
        last_rise = cyc;
        rises++;
        cfg_rx = {cfg_rx[30:0], mosi};
    end

    always @(negedge sclk) begin
        last_fall = cyc;
        if (cyc - last_rise != DIV) per_bad++;
        if (fall_cnt == 31) begin
            in_io = 1'b0;
            fall_cnt = 0;
            conv_left = conv_len;
        end else begin
            fall_cnt++;
        end
    end

    always @(negedge cs_n) begin
        cs_falls++;
        if (sclk) cs_bad++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_xfer(input int conv_wait, input bit extra_start,
                            output bit got_valid, output bit got_tmo, output int lag);
        got_valid = 0;
        got_tmo   = 0;
        lag       = -1;
        @(negedge clk);
        rises = 0;
        conv_left = conv_wait;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            start = (extra_start && k == 10);
            if (rd_valid) begin
                got_valid = 1;
                lag = cyc - last_fall;
                break;
            end
            if (err_tmo) begin
                got_tmo = 1;
                break;
            end
        end
        start = 1'b0;
    endtask

    function automatic logic [12:0] exp_cfg();
        return {1'b1, 1'b0, cfg_en, cfg_sgl, cfg_odd, cfg_addr[2], cfg_addr[1], cfg_addr[0],
                cfg_en2, cfg_im, cfg_filt[1], cfg_filt[0], cfg_spd};
    endfunction

    initial begin
        bit gv, gt;
        int lag;
        int falls0;
        bit irq_seen;
        logic [28:0] dat;

        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk(busy == 1'b0, "R9 reset busy", busy, 0);
        chk(rd_valid == 1'b0, "R5 reset valid", rd_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Sweep of configuration fields, data values and conversion delays
        for (int i = 0; i < 48; i++) begin
            cfg_addr = i[2:0]; cfg_odd = i[3]; cfg_sgl = i[4]; cfg_en = i[5] | i[0];
            cfg_en2 = i[0] ^ i[2]; cfg_im = i[1]; cfg_filt = 2'(i / 3); cfg_spd = i[4] ^ i[1];
            dat = 29'(i * 1234567 + 99);
            dev_word = {1'b0, 1'b0, i[1], dat};
            run_xfer((i % 4) * 9, (i % 8) == 3, gv, gt, lag);
            chk(gv, "R5 valid seen", gv, 1);
            chk(lag == 1, "R5 valid lag", lag, 1);
            chk({rd_eoc, rd_zero, rd_sign, rd_data} == dev_word, "R5 result fields",
                {rd_eoc, rd_zero, rd_sign, rd_data}, dev_word);
            chk(cfg_rx == {exp_cfg(), 19'b0}, "R4 config word", cfg_rx, {exp_cfg(), 19'b0});
            chk(rises == 32, "R3 rise count", rises, 32);
            chk(err_proto == 1'b0, "R7 no protocol error", err_proto, 0);
            chk(cs_n == 1'b1, "R6 cs released", cs_n, 1);
            repeat (6) @(negedge clk);
            chk(cs_n == 1'b1 && rises == 32 && !busy, "R9 extra start ignored", rises, 32);
        end

        // Protocol error: second bit set
        dev_word = {1'b0, 1'b1, 1'b0, 29'h0ABC_DEF};
        run_xfer(5, 0, gv, gt, lag);
        chk(gv, "R7 valid seen", gv, 1);
        chk(err_proto == 1'b1, "R7 protocol error flagged", err_proto, 1);
        chk(rd_data == 29'h0ABC_DEF, "R7 data kept", rd_data, 29'h0ABC_DEF);

        // Timeout
        run_xfer(1000, 0, gv, gt, lag);
        chk(gt, "R8 timeout pulse", gt, 1);
        chk(!gv, "R8 no valid", gv, 0);
        chk(rises == 0, "R8 no sclk", rises, 0);
        @(negedge clk);
        chk(cs_n == 1'b1 && err_tmo == 1'b0, "R8 cs released, single pulse", {cs_n, err_tmo}, 2'b10);
        conv_left = 0;
        repeat (3) @(negedge clk);

        // Hold chip select and monitor
        hold_cs = 1'b1;
        conv_len = 20;
        dev_word = {3'b000, 29'h1555_5555};
        run_xfer(4, 0, gv, gt, lag);
        chk(gv, "R6 hold valid", gv, 1);
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b0, "R6 cs held low", cs_n, 0);
        falls0 = cs_falls;
        irq_seen = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (conv_irq) irq_seen = 1;
        end
        chk(irq_seen, "R6 conv_irq on miso fall", irq_seen, 1);
        dev_word = {3'b001, 29'h0F0F_0F0F};
        run_xfer(6, 0, gv, gt, lag);
        chk(gv && rd_data == 29'h0F0F_0F0F && rd_sign, "R6 transfer from monitor", rd_data, 29'h0F0F_0F0F);
        chk(cs_falls == falls0, "R6 no new cs fall", cs_falls, falls0);
        hold_cs = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && !busy, "R6 release on hold drop", cs_n, 1);

        chk(per_bad == 0, "R3 sclk phase timing", per_bad, 0);
        chk(early == 0, "R2 no rise before end of conversion", early, 0);
        chk(cs_bad == 0, "R1 sclk low at cs fall", cs_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule